// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a general-purpose timer for a small controller. A free-running counter advances once every four system clocks. Two capture channels record the counter value when a chosen edge arrives on their input pins. Two compare channels change their output pins when the counter reaches a programmed value. Software reads and writes every wide value through pairs of 8-bit registers on a simple synchronous register bus.

The registers are grouped in byte pairs, and access to a pair is interlocked. A read of the counter's upper byte freezes the matching lower byte, so the two reads come from the same instant. A read of a capture's upper byte holds off new captures on that channel until the lower byte is read. A write of a compare's upper byte holds off matching on that channel until the lower byte is written. Each event sets a status flag that software clears with a two-step sequence. The enabled flags are combined into one interrupt line.

Register bus: a read returns `reg_rdata` in the same cycle that `reg_rd` is high. Its side effects (latching, holds, flag clearing) take effect at the next rising clock edge. A write takes effect at the rising edge where `reg_wr` is high. Reset is synchronous and active high.

Top module: `cc_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 16) and reads 0 after reset. It increases by exactly one every fourth clock, wraps from all ones to zero, and cannot be written. Its upper byte is at address 4 and its lower byte at address 5. Upper bytes hold counter bits CNT_W-1..8, zero-filled on read.
- R2: A read of address 4 stores the counter's lower byte at that edge. The next read of address 5 returns the stored byte, however long the gap. A read of address 5 with nothing stored returns the live lower byte.
- R3: Address 0 selects the capture edges: bits 1:0 for channel 0 and bits 3:2 for channel 1, with 0 = off, 1 = rising, 2 = falling, 3 = both. Each pin passes through two synchroniser flops. A qualifying edge stores the counter value seen just before the third rising clock edge after the pin changes. Capture values are read at addresses 6/7 (channel 0) and 8/9 (channel 1), upper byte first.
- R4: After a read of a capture's upper byte, edges on that channel store nothing until its lower byte is read.
- R5: Address 1 selects the compare actions: bits 1:0 for channel 0 and bits 3:2 for channel 1, with 0 = none, 1 = drive high, 2 = drive low, 3 = toggle. The action is applied to `cmp_pin` at the same clock edge on which the counter takes the compare value. Compare values sit at addresses 10/11 (channel 0) and 12/13 (channel 1), upper byte first.
- R6: After a write of a compare's upper byte, that channel does not match until its lower byte is written.
- R7: Status at address 3 has bit 0 for capture 0, bit 1 for capture 1, bit 2 for compare 0, bit 3 for compare 1 and bit 4 for counter wrap. Each bit is set by its event. The compare bit is set even when the action is none.
- R8: A flag clears only through two steps: a status read while the flag is set, then the lower-byte access that belongs to it. For captures and the counter that access is a read; for compares it is a write. A lower-byte access without a preceding status read leaves the flag set. An event in the clearing cycle keeps the flag set.
- R9: Address 2 holds the interrupt enables, with the same bit positions as status. `irq` is high while any enabled flag is set.
- R10: After reset, all configuration, status and capture registers read 0, both compare registers hold all ones, and both compare pins are low. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register address |
| reg_rd | input | 1 | Read strobe; side effects at the next edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| cap_pin | input | N_CAP | Capture inputs, asynchronous |
| cmp_pin | output | N_CMP | Compare outputs |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the in-line properties check several local rules:
- the counter moves only on prescaler ticks, by one at each tick;
- a capture stores the counter value from the preceding cycle, and a held capture register stays frozen;
- a compare pin moves only on a match, in the direction its action demands;
- events set their flags, and flags never drop without the lower-byte access.

Some behaviours need whole sequences that only the bench's scenarios can build. These are the end-to-end latency from a pin change to the stored value, and the coherence of the upper/lower counter reads across a long gap. They also include the two-step flag clearing order, and releasing a compare hold so that it matches at the next pass rather than at the missed one.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_LOW  = 2'd2,
    ACT_FLIP = 2'd3
  } cmp_act_e;

  localparam logic [ADDR_W-1:0] ADR_EDGE   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_ACT    = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 4'd5;
  localparam int               ADR_CAP0   = 6;

  // Edge qualifier on a synchronised sample pair.
  function automatic logic edge_hit(logic [1:0] mode, logic prev, logic cur);
    case (edge_sel_e'(mode))
      EDGE_RISE: return !prev && cur;
      EDGE_FALL: return prev && !cur;
      EDGE_ANY:  return prev != cur;
      default:   return 1'b0;
    endcase
  endfunction

  // Pin level after a compare action.
  function automatic logic pin_after(logic [1:0] act, logic pin);
    case (cmp_act_e'(act))
      ACT_HIGH: return 1'b1;
      ACT_LOW:  return 1'b0;
      ACT_FLIP: return !pin;
      default:  return pin;
    endcase
  endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             tick,
  output logic             wrap
);
  localparam int PW = $clog2(PRE_DIV);

  logic [PW-1:0] pre;

  assign tick     = (pre == PW'(PRE_DIV - 1));
  assign cnt_next = cnt + 1'b1;
  assign wrap     = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt_next;
    end
  end

  assert_count_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  assert_count_steps_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == '0);

endmodule

// File: rtl/cct_capture.sv
module cct_capture
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_hi,
  input  logic             rd_lo,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  logic sync1, sync2, prev;
  logic held;

  assign cap_evt = edge_hit(mode, prev, sync2) && !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prev    <= 1'b0;
      held    <= 1'b0;
      cap_val <= '0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      prev  <= sync2;
      if (cap_evt) cap_val <= cnt;
      if (rd_hi)      held <= 1'b1;
      else if (rd_lo) held <= 1'b0;
    end
  end

  assert_capture_value_R3: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_val == $past(cnt));
  assert_capture_off_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == EDGE_OFF) |=> $stable(cap_val));
  assert_capture_held_R4: assert property (@(posedge clk) disable iff (rst)
    held |=> $stable(cap_val));

endmodule

// File: rtl/cct_compare.sv
module cct_compare
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [1:0]       act,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cmp_val,
  output logic             pin,
  output logic             match_evt
);
  localparam int HW = CNT_W - 8;

  logic held;

  // Match is taken at the edge on which the counter becomes cmp_val.
  assign match_evt = tick && !held && (cnt_next == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '1;
      pin     <= 1'b0;
      held    <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp_val[CNT_W-1:8] <= wdata[HW-1:0];
        held               <= 1'b1;
      end
      if (wr_lo) begin
        cmp_val[7:0] <= wdata;
        held         <= 1'b0;
      end
      if (match_evt) pin <= pin_after(act, pin);
    end
  end

  assert_pin_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !match_evt |=> $stable(pin));
  assert_pin_high_R5: assert property (@(posedge clk) disable iff (rst)
    (match_evt && act == ACT_HIGH) |=> pin);
  assert_pin_low_R5: assert property (@(posedge clk) disable iff (rst)
    (match_evt && act == ACT_LOW) |=> !pin);
  assert_pin_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (match_evt && act == ACT_FLIP) |=> pin != $past(pin));
  assert_match_held_R6: assert property (@(posedge clk) disable iff (rst)
    (held && tick) |=> $stable(pin));

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 4,
  parameter int N_CAP   = 2,
  parameter int N_CMP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [N_CAP-1:0]  cap_pin,
  output logic [N_CMP-1:0]  cmp_pin,
  output logic              irq
);
  localparam int NF       = N_CAP + N_CMP + 1;
  localparam int OVF      = NF - 1;
  localparam int HW       = CNT_W - 8;
  localparam int CMP_BASE = ADR_CAP0 + 2 * N_CAP;

  logic [CNT_W-1:0]   cnt, cnt_next;
  logic               tick, wrap;
  logic [CNT_W-1:0]   cap_val [N_CAP];
  logic [CNT_W-1:0]   cmp_val [N_CMP];
  logic [NF-1:0]      evt;      // per-flag event this cycle
  logic [NF-1:0]      lo_acc;   // per-flag low-byte access this cycle
  logic [NF-1:0]      flags, armed, ien;
  logic [2*N_CAP-1:0] edge_cfg;
  logic [2*N_CMP-1:0] act_cfg;
  logic [7:0]         lo_buf;
  logic               lo_latched;
  logic               rd_stat, rd_cnt_hi, rd_cnt_lo;

  assign rd_stat   = reg_rd && reg_addr == ADR_STAT;
  assign rd_cnt_hi = reg_rd && reg_addr == ADR_CNT_HI;
  assign rd_cnt_lo = reg_rd && reg_addr == ADR_CNT_LO;

  cct_counter #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_counter (
    .clk(clk), .rst(rst), .cnt(cnt), .cnt_next(cnt_next), .tick(tick), .wrap(wrap)
  );

  assign evt[OVF]    = wrap;
  assign lo_acc[OVF] = rd_cnt_lo;

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADR_CAP0 + 2 * i);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADR_CAP0 + 2 * i + 1);
    assign lo_acc[i] = reg_rd && reg_addr == A_LO;
    cct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .pin(cap_pin[i]), .mode(edge_cfg[2*i +: 2]), .cnt(cnt),
      .rd_hi(reg_rd && reg_addr == A_HI), .rd_lo(lo_acc[i]),
      .cap_val(cap_val[i]), .cap_evt(evt[i])
    );
  end

  for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CMP_BASE + 2 * j);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CMP_BASE + 2 * j + 1);
    assign lo_acc[N_CAP+j] = reg_wr && reg_addr == A_LO;
    cct_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick), .cnt_next(cnt_next), .act(act_cfg[2*j +: 2]),
      .wr_hi(reg_wr && reg_addr == A_HI), .wr_lo(lo_acc[N_CAP+j]), .wdata(reg_wdata),
      .cmp_val(cmp_val[j]), .pin(cmp_pin[j]), .match_evt(evt[N_CAP+j])
    );
  end

  // Configuration, flags and the counter low-byte latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cfg   <= '0;
      act_cfg    <= '0;
      ien        <= '0;
      flags      <= '0;
      armed      <= '0;
      lo_buf     <= '0;
      lo_latched <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADR_EDGE) edge_cfg <= reg_wdata[2*N_CAP-1:0];
      if (reg_wr && reg_addr == ADR_ACT)  act_cfg  <= reg_wdata[2*N_CMP-1:0];
      if (reg_wr && reg_addr == ADR_IEN)  ien      <= reg_wdata[NF-1:0];
      for (int k = 0; k < NF; k++) begin
        if (evt[k])                       flags[k] <= 1'b1;
        else if (armed[k] && lo_acc[k])   flags[k] <= 1'b0;
      end
      if (rd_stat) armed <= flags;
      else         armed <= armed & ~lo_acc;
      if (rd_cnt_hi) begin
        lo_buf     <= cnt[7:0];
        lo_latched <= 1'b1;
      end else if (rd_cnt_lo) begin
        lo_latched <= 1'b0;
      end
    end
  end

  assign irq = |(flags & ien);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_EDGE:   reg_rdata[2*N_CAP-1:0] = edge_cfg;
      ADR_ACT:    reg_rdata[2*N_CMP-1:0] = act_cfg;
      ADR_IEN:    reg_rdata[NF-1:0]      = ien;
      ADR_STAT:   reg_rdata[NF-1:0]      = flags;
      ADR_CNT_HI: reg_rdata[HW-1:0]      = cnt[CNT_W-1:8];
      ADR_CNT_LO: reg_rdata              = lo_latched ? lo_buf : cnt[7:0];
      default:    reg_rdata              = '0;
    endcase
    for (int i = 0; i < N_CAP; i++) begin
      if (reg_addr == ADDR_W'(ADR_CAP0 + 2 * i))     reg_rdata[HW-1:0] = cap_val[i][CNT_W-1:8];
      if (reg_addr == ADDR_W'(ADR_CAP0 + 2 * i + 1)) reg_rdata         = cap_val[i][7:0];
    end
    for (int j = 0; j < N_CMP; j++) begin
      if (reg_addr == ADDR_W'(CMP_BASE + 2 * j))     reg_rdata[HW-1:0] = cmp_val[j][CNT_W-1:8];
      if (reg_addr == ADDR_W'(CMP_BASE + 2 * j + 1)) reg_rdata         = cmp_val[j][7:0];
    end
  end

  for (genvar k = 0; k < NF; k++) begin : g_flag_chk
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
      evt[k] |=> flags[k]);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (armed[k] && lo_acc[k] && !evt[k]) |=> !flags[k]);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (flags[k] && !lo_acc[k]) |=> flags[k]);
  end

  assert_lo_latch_R2: assert property (@(posedge clk) disable iff (rst)
    rd_cnt_hi |=> (lo_latched && lo_buf == $past(cnt[7:0])));

endmodule

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int CW = 12;            // narrow counter so a wrap fits the run
  localparam int CM = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cap_in = '0;
  logic [1:0] cmp_out;
  logic       irq;

  always #5 clk = ~clk;

  cc_timer #(.CNT_W(CW)) u_cc_timer (
    .clk(clk), .rst(rst), .reg_addr(addr), .reg_rd(rd), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .cap_pin(cap_in), .cmp_pin(cmp_out), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced at each rising edge.
  int m_pre, m_cnt, m_flags, m_armed, m_ien, m_edge, m_act, m_buf;
  bit m_latched;
  int m_cap[2], m_cmp[2];
  bit m_s1[2], m_s2[2], m_prev[2], m_chold[2], m_mhold[2];
  logic [1:0] m_pins;

  always @(posedge clk) begin : model
    int ev, lo, md, ac;
    bit tk, hit;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_flags = 0; m_armed = 0; m_ien = 0;
      m_edge = 0; m_act = 0; m_buf = 0; m_latched = 0; m_pins = 2'b00;
      for (int i = 0; i < 2; i++) begin
        m_cap[i] = 0; m_cmp[i] = CM; m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0;
        m_chold[i] = 0; m_mhold[i] = 0;
      end
    end else begin
      tk = (m_pre == 3);
      ev = 0;
      for (int i = 0; i < 2; i++) begin
        md  = (m_edge >> (2 * i)) & 3;
        hit = (md == 1 && !m_prev[i] && m_s2[i]) || (md == 2 && m_prev[i] && !m_s2[i]) ||
              (md == 3 && m_prev[i] != m_s2[i]);
        if (hit && !m_chold[i]) ev |= (1 << i);
      end
      for (int j = 0; j < 2; j++)
        if (tk && !m_mhold[j] && ((m_cnt + 1) & CM) == m_cmp[j]) ev |= (1 << (2 + j));
      if (tk && m_cnt == CM) ev |= 16;
      lo = 0;
      if (rd && addr == 7)  lo |= 1;
      if (rd && addr == 9)  lo |= 2;
      if (wr && addr == 11) lo |= 4;
      if (wr && addr == 13) lo |= 8;
      if (rd && addr == 5)  lo |= 16;
      m_armed = (rd && addr == 3) ? m_flags : (m_armed & ~lo);
      m_flags = (m_flags | ev) & ~(((rd && addr == 3) ? 0 : 0) | 0) & ~(lo & ~ev & (m_armed_pre_mask(lo)));
      for (int i = 0; i < 2; i++) begin
        if ((ev >> i) & 1) m_cap[i] = m_cnt;
        if (rd && addr == 6 + 2 * i)      m_chold[i] = 1;
        else if (rd && addr == 7 + 2 * i) m_chold[i] = 0;
      end
      for (int j = 0; j < 2; j++) begin
        ac = (m_act >> (2 * j)) & 3;
        if ((ev >> (2 + j)) & 1)
          m_pins[j] = (ac == 1) ? 1'b1 : (ac == 2) ? 1'b0 : (ac == 3) ? ~m_pins[j] : m_pins[j];
        if (wr && addr == 10 + 2 * j) begin
          m_cmp[j] = (m_cmp[j] & 255) | ((int'(wdata) & (CM >> 8)) << 8);
          m_mhold[j] = 1;
        end
        if (wr && addr == 11 + 2 * j) begin
          m_cmp[j] = (m_cmp[j] & ~255) | int'(wdata);
          m_mhold[j] = 0;
        end
      end
      if (wr && addr == 0) m_edge = int'(wdata) & 15;
      if (wr && addr == 1) m_act  = int'(wdata) & 15;
      if (wr && addr == 2) m_ien  = int'(wdata) & 31;
      if (rd && addr == 4) begin m_buf = m_cnt & 255; m_latched = 1; end
      else if (rd && addr == 5) m_latched = 0;
      for (int i = 0; i < 2; i++) begin
        m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = cap_in[i];
      end
      if (tk) m_cnt = (m_cnt + 1) & CM;
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  // Armed state before this edge's update, kept by a separate shadow.
  int m_armed_q = 0;
  always @(negedge clk) m_armed_q = m_armed;
  function automatic int m_armed_pre_mask(input int lo_bits);
    return m_armed_q & lo_bits;
  endfunction

  function automatic int model_read(input int a);
    case (a)
      0: return m_edge;
      1: return m_act;
      2: return m_ien;
      3: return m_flags;
      4: return (m_cnt >> 8) & 255;
      5: return m_latched ? m_buf : (m_cnt & 255);
      6: return m_cap[0] >> 8;   7: return m_cap[0] & 255;
      8: return m_cap[1] >> 8;   9: return m_cap[1] & 255;
      10: return m_cmp[0] >> 8;  11: return m_cmp[0] & 255;
      12: return m_cmp[1] >> 8;  13: return m_cmp[1] & 255;
      default: return 0;
    endcase
  endfunction

  // Outputs against the model on every cycle (R5 pins, R9 interrupt).
  always @(negedge clk) begin
    if (!rst) begin
      check("R5", cmp_out, m_pins);
      check("R9", irq, ((m_flags & m_ien) != 0));
    end
  end

  task automatic rd_reg(input int a, input string req, output logic [7:0] v);
    @(negedge clk); addr = 4'(a); rd = 1'b1; #1;
    v = rdata;
    check(req, rdata, model_read(a));
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); addr = 4'(a); wdata = 8'(d); wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic set_cmp(input int j, input int val);
    wr_reg(10 + 2 * j, (val >> 8) & 255);
    wr_reg(11 + 2 * j, val & 255);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    logic [7:0] v, v2, h;
    int e, exp_cap;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10: reset values over the whole map
    for (int a = 0; a < 16; a++) rd_reg(a, "R10", v);
    rd_reg(10, "R10", v); check("R10 cmp hi all ones", v, 8'h0F);
    rd_reg(3, "R10", v);  check("R10 status zero", v, 8'h00);
    check("R10 pins low", cmp_out, 2'b00);

    // R1: two reads eight clocks apart differ by two counts
    rd_reg(5, "R1", v);
    idle(7);
    rd_reg(5, "R1", v2);
    check("R1 step", 8'(v2 - v), 8'd2);

    // R2: coherent upper/lower read across a gap
    rd_reg(4, "R2", h);
    e = m_buf;
    idle(37);
    rd_reg(5, "R2", v);
    check("R2 latched low", v, e);
    rd_reg(5, "R2 live", v);

    // R3: ch0 rising, ch1 falling
    wr_reg(0, 8'h09);
    @(negedge clk); cap_in = 2'b11;
    @(posedge clk); @(posedge clk); #1 exp_cap = m_cnt;
    idle(4);
    rd_reg(6, "R3", v); rd_reg(7, "R3", v2);
    check("R3 capture value", {v[3:0], v2}, exp_cap);
    rd_reg(3, "R3", v); check("R3 only ch0 flagged", v & 8'h03, 8'h01);
    @(negedge clk); cap_in = 2'b00;
    idle(6);
    rd_reg(7, "R3 ch0 ignores fall", v2);
    rd_reg(8, "R3", v); rd_reg(9, "R3", v);
    wr_reg(0, 8'h0F);  // both edges on both channels
    @(negedge clk); cap_in = 2'b10;
    idle(6);
    rd_reg(8, "R3 both", v); rd_reg(9, "R3 both", v);

    // R4: hold after upper read blocks captures
    rd_reg(6, "R4", h);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(8);
    rd_reg(7, "R4 held", v);
    check("R4 no capture while held", v, v2);
    @(negedge clk); cap_in[0] = 1'b0;
    idle(8);
    rd_reg(6, "R4 released", v); rd_reg(7, "R4 released", v);

    // R8: status-then-low clearing, and low without status
    rd_reg(3, "R8", v);
    rd_reg(7, "R8", v);
    rd_reg(3, "R8", v); check("R8 cleared ch0", v & 8'h01, 8'h00);
    rd_reg(9, "R8", v);                    // armed from the read above
    @(negedge clk); cap_in[0] = 1'b1;
    idle(6);
    rd_reg(7, "R8", v);                    // no status read in between
    rd_reg(3, "R8", v); check("R8 kept without status", v & 8'h01, 8'h01);
    rd_reg(7, "R8", v);
    rd_reg(3, "R8", v); check("R8 cleared after status", v & 8'h01, 8'h00);

    // R5/R9: compare actions and interrupt
    wr_reg(2, 8'h0C);
    wr_reg(1, 8'hD);   // ch0 high, ch1 toggle
    set_cmp(0, (m_cnt + 6) & CM);
    set_cmp(1, (m_cnt + 6) & CM);
    idle(40);
    check("R5 set and toggle", cmp_out, 2'b11);
    check("R9 irq on compare", irq, 1'b1);
    rd_reg(3, "R7", v); check("R7 compare flags", v & 8'h0C, 8'h0C);
    wr_reg(11, m_cmp[0] & 255); wr_reg(13, m_cmp[1] & 255);
    check("R9 irq cleared", irq, 1'b0);
    wr_reg(1, 8'hE);   // ch0 low, ch1 toggle
    set_cmp(0, (m_cnt + 6) & CM);
    set_cmp(1, (m_cnt + 6) & CM);
    idle(40);
    check("R5 clear and toggle", cmp_out, 2'b00);
    wr_reg(1, 8'h0);   // none: flag yet no pin change
    set_cmp(0, (m_cnt + 6) & CM);
    idle(40);
    check("R5 none", cmp_out, 2'b00);
    rd_reg(3, "R7 flag with no action", v);

    // R6: upper write holds off matching
    wr_reg(1, 8'h3);   // ch0 toggle
    rd_reg(3, "R6", v); wr_reg(11, m_cmp[0] & 255);   // clear ch0 flag
    e = (m_cnt + 8) & CM;
    wr_reg(11, e & 255);
    wr_reg(10, (e >> 8) & 255);
    idle(60);
    check("R6 held pin", cmp_out[0], 1'b0);
    rd_reg(3, "R6 held flag", v); check("R6 no match while held", v & 8'h04, 8'h00);
    wr_reg(11, e & 255);
    idle(40);
    check("R6 missed match stays missed", cmp_out[0], 1'b0);

    // R7/R8/R9: counter wrap
    wr_reg(2, 8'h10);
    while (m_cnt != CM - 2) @(posedge clk);
    idle(16);
    rd_reg(3, "R7 wrap", v); check("R7 wrap flag", v & 8'h10, 8'h10);
    check("R9 irq on wrap", irq, 1'b1);
    rd_reg(5, "R8 wrap clear", v);
    rd_reg(3, "R8 wrap clear", v); check("R8 wrap cleared", v & 8'h10, 8'h00);
    check("R1 wrapped small", m_cnt < 16, 1'b1);

    idle(4);
    finish_run();
  end
endmodule